// File: doc/BRIEF.md
# Page-Buffered Byte Store with Timed Commit

This block sits behind a two-wire serial slave's protocol engine and holds a 256-byte storage array. The engine hands it a starting word address, then one strobe for each data byte received. The bytes gather in a small page buffer, and a valid bit records each slot that was filled. Nothing reaches the array until the engine reports a Stop condition. A Stop starts a self-timed write cycle. During that cycle `busy` stays high, and when the cycle ends the buffered slots are copied into the array in one step.

Only the low bits of the write pointer advance, so a long burst wraps inside its page and later bytes overwrite earlier ones. The upper half of the array is never writable. It reads back as a fixed node identifier placed at the top of the address space, and every other location in that half reads as FFh. A supply-inhibit input cancels a pending commit. A repeated Start throws the buffer away. A separate read port with a one-cycle latency serves the engine's read path at any time.

Top module: `page_commit_store`

## Requirements
- R1: After reset `busy` is 0 and every lower-half location (00h-7Fh) reads FFh; read data appears on `rd_data` one clock after `rd_addr` is sampled.
- R2: A byte strobe stores its byte at the pointer, and then only the low log2(PAGE_BYTES) pointer bits increment; the page bits loaded by `addr_load` stay fixed.
- R3: When more than PAGE_BYTES bytes arrive, the pointer wraps to the first slot of the same page, and the newer bytes replace the older ones in those slots.
- R4: The array does not change before a Stop, and it does not change while `busy` is high. Buffered bytes become readable only after `busy` falls.
- R5: A commit writes only the slots filled in the transaction. The other bytes of that page keep their earlier contents.
- R6: Locations 80h-FFh never change. Bytes aimed at them are dropped, but the write cycle (`busy`) still runs.
- R7: A Stop that has at least one buffered byte, with `busy` low and inhibit low, raises `busy` at the next clock edge and holds it for exactly WC_CYCLES clocks.
- R8: A Stop seen while `write_inhibit` is 1 starts no write cycle and discards the buffer.
- R9: A repeated Start (`restart_evt`) discards the buffer and starts no write cycle.
- R10: While `busy` is high, `addr_load`, `byte_strobe`, `stop_evt` and `restart_evt` have no effect.
- R11: Identity bytes are the 3-byte prefix, most significant byte first, followed by the extension bytes. With ID_WIDE=0 they fill FAh-FFh using the low 3 extension bytes. With ID_WIDE=1 they fill F8h-FFh using all 5 extension bytes. Other upper-half addresses read FFh.
- R12: A Stop with no buffered bytes starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load write pointer from `addr_in`, clear valid mask |
| addr_in | input | 8 | Word address of the transaction |
| byte_strobe | input | 1 | One received data byte is on `byte_in` |
| byte_in | input | 8 | Received data byte |
| stop_evt | input | 1 | Stop condition ended the transaction |
| restart_evt | input | 1 | Repeated Start ended the transaction |
| write_inhibit | input | 1 | Low-supply inhibit; blocks commits |
| busy | output | 1 | Self-timed write cycle in progress |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, one cycle after `rd_addr` |

## Verification
A wrong pointer or a wrong valid mask does not show up at the ports until the write cycle ends. Only then does a read-back reveal the misplaced byte or the clobbered neighbour, roughly WC_CYCLES plus two clocks after the Stop. A faulty timer shows earlier, in how long `busy` stays high measured from the Stop. The bench therefore counts the busy window on every commit, and it reads the same locations once during the cycle and once after it. A leaked write into the protected half or a discarded buffer that was wrongly kept appears at the first read-back of that address.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Advance only the in-page bits of a write pointer.
  function automatic logic [7:0] in_page_next(input logic [7:0] ptr, input logic [7:0] lo_mask);
    return (ptr & ~lo_mask) | ((ptr + 8'd1) & lo_mask);
  endfunction

  // Identity byte for an upper-half address; FFh outside the identifier window.
  function automatic logic [7:0] node_id_byte(input logic [7:0] a, input logic wide,
                                              input logic [23:0] prefix, input logic [39:0] ext);
    int first;
    int idx;
    int n_ext;
    first = wide ? 248 : 250;
    n_ext = wide ? 5 : 3;
    idx   = int'(a) - first;
    if (idx < 0) return 8'hFF;
    if (idx < 3) return 8'(prefix >> (8 * (2 - idx)));
    return 8'(ext >> (8 * (n_ext - 1 - (idx - 3))));
  endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    load_en,
  input  logic [7:0]              load_addr,
  input  logic                    byte_en,
  input  logic [7:0]              byte_data,
  output logic [7:0]              ptr,
  output logic [PAGE_BYTES-1:0]   mask,
  output logic [PAGE_BYTES*8-1:0] data_flat
);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [7:0] LO_MASK = 8'(PAGE_BYTES - 1);

  logic [PB-1:0] slot;
  assign slot = ptr[PB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      mask      <= '0;
      data_flat <= '0;
    end else if (clear) begin
      mask <= '0;
    end else if (load_en) begin
      ptr  <= load_addr;
      mask <= '0;
    end else if (byte_en) begin
      data_flat[8*slot +: 8] <= byte_data;
      mask[slot]             <= 1'b1;
      ptr                    <= pgw_pkg::in_page_next(ptr, LO_MASK);
    end
  end
endmodule

// File: rtl/pgw_commit_timer.sv
module pgw_commit_timer #(
  parameter int WC_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WC_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(WC_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
  parameter int          PAGE_BYTES = 8,
  parameter bit          ID_WIDE    = 1'b0,
  parameter logic [23:0] ID_PREFIX  = 24'h3CA107,
  parameter logic [39:0] ID_EXT     = 40'h5D62E91084
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PAGE_BYTES-1:0]   slot_we,
  input  logic [6:0]              page_base,
  input  logic [PAGE_BYTES*8-1:0] slot_data,
  input  logic [7:0]              rd_addr,
  output logic [7:0]              rd_data
);
  localparam int LO_DEPTH = 128;
  localparam logic [6:0] SLOT_MASK = 7'(PAGE_BYTES - 1);

  logic [7:0] lo_mem [LO_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LO_DEPTH; i++) lo_mem[i] <= 8'hFF;
    end else begin
      for (int s = 0; s < PAGE_BYTES; s++)
        if (slot_we[s]) lo_mem[(page_base & ~SLOT_MASK) | 7'(s)] <= slot_data[8*s +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'hFF;
    else        rd_data <= rd_addr[7] ? pgw_pkg::node_id_byte(rd_addr, ID_WIDE, ID_PREFIX, ID_EXT)
                                      : lo_mem[rd_addr[6:0]];
  end
endmodule

// File: rtl/page_commit_store.sv
module page_commit_store #(
  parameter int          PAGE_BYTES = 8,
  parameter int          WC_CYCLES  = 625000,
  parameter bit          ID_WIDE    = 1'b0,
  parameter logic [23:0] ID_PREFIX  = 24'h3CA107,
  parameter logic [39:0] ID_EXT     = 40'h5D62E91084
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_load,
  input  logic [7:0] addr_in,
  input  logic       byte_strobe,
  input  logic [7:0] byte_in,
  input  logic       stop_evt,
  input  logic       restart_evt,
  input  logic       write_inhibit,
  output logic       busy,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  logic                    idle;
  logic                    commit_start;
  logic                    commit_done;
  logic                    drop_buf;
  logic                    page_hi;
  logic [7:0]              ptr;
  logic [PAGE_BYTES-1:0]   mask;
  logic [PAGE_BYTES-1:0]   slot_we;
  logic [PAGE_BYTES*8-1:0] buf_data;

  assign idle         = !busy;
  assign commit_start = idle && stop_evt && (mask != '0) && !write_inhibit;
  assign drop_buf     = idle && ((stop_evt && !commit_start) || restart_evt);
  assign page_hi      = ptr[7];
  assign slot_we      = (commit_done && !page_hi && !write_inhibit) ? mask : '0;

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clear(drop_buf || commit_done),
    .load_en(idle && addr_load), .load_addr(addr_in),
    .byte_en(idle && byte_strobe), .byte_data(byte_in),
    .ptr(ptr), .mask(mask), .data_flat(buf_data)
  );

  pgw_commit_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(commit_start), .busy(busy), .done(commit_done)
  );

  pgw_store #(.PAGE_BYTES(PAGE_BYTES), .ID_WIDE(ID_WIDE), .ID_PREFIX(ID_PREFIX), .ID_EXT(ID_EXT)) u_store (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .page_base(ptr[6:0]),
    .slot_data(buf_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int PAGE_BYTES = 8,
  parameter int WC_CYCLES  = 625000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  stop_evt,
  input logic                  restart_evt,
  input logic                  write_inhibit,
  input logic [PAGE_BYTES-1:0] mask,
  input logic [PAGE_BYTES-1:0] slot_we,
  input logic                  commit_done,
  input logic                  page_hi
);
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else        busy_len <= busy ? busy_len + 1 : 0;
  end

  a_r7_rise_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));
  a_r7_window_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_len) == WC_CYCLES - 1));
  a_r8_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && write_inhibit && !busy) |=> !busy);
  a_r9_restart_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && !stop_evt && !busy) |=> (!busy && mask == '0));
  a_r12_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !busy && mask == '0) |=> !busy);
  a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_done) |=> $stable(mask));
  a_r4_write_at_end_only: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we != '0) |-> commit_done);
  a_r6_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we != '0) |-> !page_hi);
  a_r5_only_filled_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_we & ~mask) == '0);
endmodule

bind page_commit_store pgw_checker #(.PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)) u_pgw_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stop_evt(stop_evt), .restart_evt(restart_evt),
  .write_inhibit(write_inhibit), .mask(mask), .slot_we(slot_we),
  .commit_done(commit_done), .page_hi(page_hi)
);

// File: tb/test_page_commit_store.sv
`timescale 1ns/1ps
module test_page_commit_store;
  localparam int PG = 8;
  localparam int WC = 40;
  localparam logic [23:0] PFX = 24'h3CA107;
  localparam logic [39:0] EXT = 40'h5D62E91084;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 0, byte_strobe = 0, stop_evt = 0, restart_evt = 0, write_inhibit = 0;
  logic [7:0] addr_in = 0, byte_in = 0, rd_addr = 0;
  logic busy, busy_w;
  logic [7:0] rd_data, rd_data_w;

  always #4 clk = ~clk;

  page_commit_store #(.PAGE_BYTES(PG), .WC_CYCLES(WC), .ID_WIDE(1'b0), .ID_PREFIX(PFX), .ID_EXT(EXT))
    i_page_commit_store (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_strobe(byte_strobe), .byte_in(byte_in), .stop_evt(stop_evt),
    .restart_evt(restart_evt), .write_inhibit(write_inhibit), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  page_commit_store #(.PAGE_BYTES(PG), .WC_CYCLES(WC), .ID_WIDE(1'b1), .ID_PREFIX(PFX), .ID_EXT(EXT))
    i_page_commit_store_w (
    .clk(clk), .rst_n(rst_n), .addr_load(1'b0), .addr_in(8'h00),
    .byte_strobe(1'b0), .byte_in(8'h00), .stop_evt(1'b0),
    .restart_evt(1'b0), .write_inhibit(1'b0), .busy(busy_w),
    .rd_addr(rd_addr), .rd_data(rd_data_w));

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] exp_lo [128];
  logic [7:0] m_buf [PG];
  logic [7:0] m_mask;
  logic [7:0] m_ptr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hi(input logic [7:0] a, input bit wide);
    logic [63:0] v;
    int off;
    if (wide) begin
      v = {PFX, EXT};
      off = int'(a) - 248;
      if (off < 0) return 8'hFF;
      return v[63 - 8*off -: 8];
    end
    v = {16'h0, PFX, EXT[23:0]};
    off = int'(a) - 250;
    if (off < 0) return 8'hFF;
    return v[47 - 8*off -: 8];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return a[7] ? exp_hi(a, 1'b0) : exp_lo[a[6:0]];
  endfunction

  task automatic pulse_load(input logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_strobe = 1; byte_in = d;
    @(negedge clk); byte_strobe = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask
  task automatic pulse_restart();
    @(negedge clk); restart_evt = 1;
    @(negedge clk); restart_evt = 0;
  endtask

  task automatic m_load(input logic [7:0] a);
    pulse_load(a); m_ptr = a; m_mask = 0;
  endtask
  task automatic m_byte(input logic [7:0] d);
    pulse_byte(d);
    m_buf[m_ptr[2:0]] = d;
    m_mask[m_ptr[2:0]] = 1'b1;
    m_ptr = {m_ptr[7:3], m_ptr[2:0] + 3'd1};
  endtask
  task automatic m_restart();
    pulse_restart(); m_mask = 0;
    chk("R9 no busy after restart", busy, 0);
  endtask

  // Stop; optionally peek at an address during the write cycle (R4).
  task automatic m_stop(input bit peek, input logic [7:0] peek_addr);
    bit will;
    int n;
    logic [7:0] old_v;
    will = (m_mask != 0) && !write_inhibit;
    old_v = exp_rd(peek_addr);
    pulse_stop();
    chk("R7 busy after stop", busy, will);
    if (will) begin
      n = 0;
      while (busy && n < 1000) begin
        n++;
        if (peek && n == 1) rd_addr = peek_addr;
        if (peek && n == 2) chk("R4 array unchanged during busy", rd_data, old_v);
        @(negedge clk);
      end
      chk("R7 busy length", n, WC);
      if (!m_ptr[7])
        for (int s = 0; s < PG; s++)
          if (m_mask[s]) exp_lo[{m_ptr[6:3], 3'(s)}] = m_buf[s];
    end
    m_mask = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(req, rd_data, exp_rd(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [7:0] pg;
    int nb;
    int kind;
    for (int i = 0; i < 128; i++) exp_lo[i] = 8'hFF;
    m_mask = 0; m_ptr = 0;
    for (int s = 0; s < PG; s++) m_buf[s] = 0;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy after reset", busy, 0);
    rd_chk("R1 low half erased 00h", 8'h00);
    rd_chk("R1 low half erased 7Fh", 8'h7F);
    // R11 identity placement, both widths
    for (int k = 248; k < 256; k++) begin
      @(negedge clk); rd_addr = 8'(k);
      @(negedge clk);
      chk("R11 narrow identity", rd_data, exp_hi(8'(k), 1'b0));
      chk("R11 wide identity", rd_data_w, exp_hi(8'(k), 1'b1));
    end
    rd_chk("R11 upper non-id FFh", 8'h80);

    // R2/R4/R5 short write in middle of page
    m_load(8'h12);
    m_byte(8'hA1); m_byte(8'hB2); m_byte(8'hC3);
    rd_chk("R4 unchanged before stop", 8'h12);
    m_stop(1'b1, 8'h13);
    chk("R2 slot 12h", exp_lo[8'h12], 8'hA1);
    rd_chk("R2 byte at 12h", 8'h12);
    rd_chk("R2 byte at 14h", 8'h14);
    rd_chk("R5 neighbour 11h kept", 8'h11);
    rd_chk("R5 neighbour 15h kept", 8'h15);

    // R3 wraparound: start at slot 6 of page 18h, 10 bytes
    m_load(8'h1E);
    for (int k = 0; k < 10; k++) m_byte(8'(8'hD0 + k));
    m_stop(1'b0, 8'h00);
    chk("R3 model 1Eh", exp_lo[8'h1E], 8'hD8);
    rd_chk("R3 wrapped 1Eh newest", 8'h1E);
    rd_chk("R3 wrapped 1Fh newest", 8'h1F);
    rd_chk("R3 slot 18h", 8'h18);
    rd_chk("R3 next page 20h untouched", 8'h20);

    // R6 writes to protected half: busy runs, contents fixed
    m_load(8'hF9);
    m_byte(8'h00); m_byte(8'h11); m_byte(8'h22);
    m_stop(1'b0, 8'h00);
    rd_chk("R6 FAh unchanged", 8'hFA);
    rd_chk("R6 FBh unchanged", 8'hFB);
    m_load(8'h80); m_byte(8'h55);
    m_stop(1'b0, 8'h00);
    rd_chk("R6 80h unchanged", 8'h80);
    rd_chk("R6 low alias 00h unchanged", 8'h00);

    // R8 inhibit
    m_load(8'h30); m_byte(8'h99);
    @(negedge clk); write_inhibit = 1;
    m_stop(1'b0, 8'h00);
    chk("R8 no busy under inhibit", busy, 0);
    @(negedge clk); write_inhibit = 0;
    pulse_stop();
    chk("R8 buffer discarded", busy, 0);
    rd_chk("R8 30h unchanged", 8'h30);

    // R9 restart
    m_load(8'h40); m_byte(8'h77);
    m_restart();
    pulse_stop();
    chk("R9 buffer discarded", busy, 0);
    rd_chk("R9 40h unchanged", 8'h40);

    // R12 empty stop
    m_load(8'h48);
    pulse_stop();
    chk("R12 empty stop no busy", busy, 0);

    // R10 strobes ignored while busy
    m_load(8'h60); m_byte(8'h3C);
    pulse_stop();
    chk("R10 busy started", busy, 1);
    pulse_load(8'h50); pulse_byte(8'h66); pulse_byte(8'h67); pulse_restart(); pulse_stop();
    while (busy) @(negedge clk);
    exp_lo[8'h60] = 8'h3C;
    m_mask = 0;
    rd_chk("R10 commit survived restart in busy", 8'h60);
    pulse_stop();
    chk("R10 nothing captured while busy", busy, 0);
    rd_chk("R10 50h unchanged", 8'h50);
    rd_chk("R10 61h unchanged", 8'h61);

    // Random transactions
    for (int it = 0; it < 60; it++) begin
      a = 8'($urandom);
      if ($urandom % 4 != 0) a[7] = 1'b0;
      pg = {a[7:3], 3'b000};
      m_load(a);
      nb = 1 + int'($urandom % (2 * PG));
      for (int k = 0; k < nb; k++) m_byte(8'($urandom));
      kind = int'($urandom % 10);
      if (kind == 0) m_restart();
      else if (kind == 1) begin
        @(negedge clk); write_inhibit = 1;
        m_stop(1'b0, 8'h00);
        @(negedge clk); write_inhibit = 0;
      end else m_stop(1'b0, 8'h00);
      for (int k = 0; k < 3; k++) rd_chk("R2 R3 R5 random page readback", pg | 8'($urandom % PG));
      rd_chk("R6 random readback", 8'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule